// File: doc/BRIEF.md
# Receive Delay Tap and Phase Alignment Controller

This block sets the input delay-chain tap for one receive lane. The tap value is a 6-bit setting that feeds an external delay line, and the delayed lane data comes back to the controller as one parallel word per slow-clock cycle. All inputs are sampled in the slow clock domain, and the design uses one clock.

The block has two modes. In manual mode, software-style enable and direction inputs step the tap up or down by one per clock, and a clear input returns it to zero. In alignment mode the block trains on its own. It walks every tap from 0 to 63 and spends a fixed dwell at each one. If any received word differs from the first word captured at that tap, the tap is marked unstable. At the end of the walk the block chooses the centre of the longest run of stable taps, sets the tap there and raises a lock flag. It also shows the chosen tap on a separate report output.

Alignment only runs when the lane is in full-rate mode. When the lane is at half rate, training stays idle and the lock flag stays low.

Top module: `rx_tap_align_ctrl`

## Requirements
- R1: While `rst_n` is low, and at release, `tap` is 0, `locked` is 0 and `lock_tap` is 0.
- R2: With `align_mode`=0 and `dly_clr`=0, each clock with `dly_en`=1 changes `tap` by +1 when `dly_up`=1 and by -1 when `dly_up`=0. A clock with `dly_en`=0 leaves `tap` unchanged.
- R3: Manual stepping saturates: an up step at 63 leaves 63, and a down step at 0 leaves 0. The tap never wraps.
- R4: With `align_mode`=0, `dly_clr`=1 sets `tap` to 0 on the next clock, whatever `dly_en` and `dly_up` are.
- R5: Training is active when `align_mode`=1 and `full_rate`=1. While it is active, a clock with `dly_en`=0 freezes training: `tap` holds and no dwell progress is made.
- R6: Training starts on the first enabled clock after idle by setting `tap` to 0. Each tap then takes one settle clock followed by DWELL (default 4) compare clocks. A tap is stable only if every compared word equals the word captured in its settle clock. With defaults, `locked` rises exactly 321 enabled clocks after the start.
- R7: After tap 63 is judged, `tap` and `lock_tap` take the value start+(len-1)/2 of the longest stable run, and `locked` rises in the same clock. When two runs have equal length, the one at the lower taps wins.
- R8: `lock_tap` is 0 whenever `locked` is 0, and it equals `tap` whenever `locked` is 1.
- R9: In alignment mode, `dly_up` has no effect. While locked, `tap` and `locked` hold under any `dly_en`/`dly_up` activity.
- R10: If no tap is stable, `locked` stays 0. The sweep restarts at tap 0 in the clock after tap 63 is judged and then continues to tap 1.
- R11: In active alignment mode, `dly_clr`=1 drops `locked` and sets `tap` to 0 on the next clock. This also holds in the clock where the lock decision would have fallen. Training restarts once `dly_en` is 1.
- R12: With `align_mode`=1 and `full_rate`=0, training is inactive: `locked` falls on the next clock and then stays 0, and `tap` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (parallel) clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_rate | input | 1 | 1 = lane in full-rate mode (training allowed), 0 = half rate |
| align_mode | input | 1 | 1 = automatic alignment, 0 = manual stepping |
| dly_en | input | 1 | Manual step enable, or training run/permit |
| dly_up | input | 1 | Manual direction: 1 up, 0 down |
| dly_clr | input | 1 | Clear the tap (manual) or restart training (alignment) |
| rx_word | input | WORD_W | Lane word sampled through the current tap |
| tap | output | TAP_W | Tap setting driving the delay line |
| locked | output | 1 | Training finished, data usable |
| lock_tap | output | TAP_W | Chosen tap while locked, else 0 |

## Verification
Two pairs of functions can land in the same clock. The first is the clear input and a manual step: the bench holds `dly_clr` together with `dly_en`/`dly_up` high at a non-zero tap and expects 0, not the stepped value. The second is the alignment restart and the lock decision: the bench raises `dly_clr` exactly in the 321st enabled clock, when tap 63 is judged. It then expects `locked` low and `tap` at 0 instead of the window centre. The delay line is modelled as a tap-dependent word source that is constant inside chosen tap windows and toggles every clock outside them. This lets each training outcome be predicted from the window table alone.

// File: rtl/rx_tap_pkg.sv
`timescale 1ns/1ps
package rx_tap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_DWELL  = 2'd2,
      ST_LOCK   = 2'd3
   } align_st_e;
endpackage

// File: rtl/rx_tap_stepper.sv
`timescale 1ns/1ps
module rx_tap_stepper #(
   parameter int TAP_W = 6
) (
   input  logic [TAP_W-1:0] cur_tap,
   input  logic             step_en,
   input  logic             step_up,
   input  logic             clr,
   output logic [TAP_W-1:0] next_tap
);
   localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

   always_comb begin
      next_tap = cur_tap;
      if (clr)
         next_tap = '0;
      else if (step_en && step_up && cur_tap != TOP)
         next_tap = cur_tap + 1'b1;
      else if (step_en && !step_up && cur_tap != '0)
         next_tap = cur_tap - 1'b1;
   end
endmodule

// File: rtl/rx_eye_window.sv
`timescale 1ns/1ps
module rx_eye_window #(
   parameter int TAP_W    = 6,
   parameter bit ROUND_UP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             eval,
   input  logic             tap_ok,
   input  logic [TAP_W-1:0] tap_idx,
   output logic             found,
   output logic [TAP_W-1:0] center
);
   localparam int LEN_W = TAP_W + 1;

   logic [LEN_W-1:0] cur_len, best_len, n_cur_len, n_best_len, half;
   logic [TAP_W-1:0] cur_start, best_start, n_cur_start, n_best_start;
   logic [LEN_W-1:0] ctr_sum;

   always_comb begin
      n_cur_len    = tap_ok ? cur_len + 1'b1 : '0;
      n_cur_start  = (tap_ok && cur_len == '0) ? tap_idx : cur_start;
      n_best_len   = best_len;
      n_best_start = best_start;
      if (tap_ok && n_cur_len > best_len) begin
         n_best_len   = n_cur_len;
         n_best_start = n_cur_start;
      end
   end

   generate
      if (ROUND_UP) begin : g_round_up
         assign half = n_best_len >> 1;
      end else begin : g_round_down
         assign half = (n_best_len - 1'b1) >> 1;
      end
   endgenerate

   assign ctr_sum = {1'b0, n_best_start} + half;
   assign center  = ctr_sum[TAP_W-1:0];
   assign found   = (n_best_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_len    <= '0;
         cur_start  <= '0;
         best_len   <= '0;
         best_start <= '0;
      end else if (clear) begin
         cur_len    <= '0;
         cur_start  <= '0;
         best_len   <= '0;
         best_start <= '0;
      end else if (eval) begin
         cur_len    <= n_cur_len;
         cur_start  <= n_cur_start;
         best_len   <= n_best_len;
         best_start <= n_best_start;
      end
   end

   // R7: the longest run seen never shrinks during a sweep
   assert_best_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !clear) |=> best_len >= $past(best_len));

   // R6: an unstable tap ends the current run
   assert_run_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !clear && !tap_ok) |=> cur_len == '0);
endmodule

// File: rtl/rx_tap_align_ctrl.sv
`timescale 1ns/1ps
module rx_tap_align_ctrl #(
   parameter int TAP_W    = 6,
   parameter int WORD_W   = 10,
   parameter int DWELL    = 4,
   parameter bit ROUND_UP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_rate,
   input  logic              align_mode,
   input  logic              dly_en,
   input  logic              dly_up,
   input  logic              dly_clr,
   input  logic [WORD_W-1:0] rx_word,
   output logic [TAP_W-1:0]  tap,
   output logic              locked,
   output logic [TAP_W-1:0]  lock_tap
);
   import rx_tap_pkg::*;

   localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
   localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);

   generate
      if (TAP_W < 2 || TAP_W > 10) begin : g_bad_tap_w
         $error("rx_tap_align_ctrl: TAP_W must be 2..10");
      end
      if (DWELL < 1) begin : g_bad_dwell
         $error("rx_tap_align_ctrl: DWELL must be at least 1");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("rx_tap_align_ctrl: WORD_W must be at least 1");
      end
   endgenerate

   align_st_e         st;
   logic [WORD_W-1:0] ref_word;
   logic [CNT_W-1:0]  cnt;
   logic              bad;
   logic [TAP_W-1:0]  man_next, ctr_tap;
   logic              align_act, diff, trk_eval, trk_clear, trk_found, last_word;

   assign align_act = align_mode && full_rate;
   assign diff      = (rx_word != ref_word);
   assign last_word = (cnt == CNT_LAST);
   assign trk_eval  = align_act && !dly_clr && dly_en && st == ST_DWELL && last_word;
   assign trk_clear = (st == ST_IDLE);

   rx_tap_stepper #(.TAP_W(TAP_W)) u_step (
      .cur_tap (tap),
      .step_en (dly_en),
      .step_up (dly_up),
      .clr     (dly_clr),
      .next_tap(man_next)
   );

   rx_eye_window #(.TAP_W(TAP_W), .ROUND_UP(ROUND_UP)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (trk_clear),
      .eval   (trk_eval),
      .tap_ok (!(bad || diff)),
      .tap_idx(tap),
      .found  (trk_found),
      .center (ctr_tap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         tap      <= '0;
         locked   <= 1'b0;
         lock_tap <= '0;
         ref_word <= '0;
         cnt      <= '0;
         bad      <= 1'b0;
      end else if (!align_mode) begin
         tap      <= man_next;
         st       <= ST_IDLE;
         locked   <= 1'b0;
         lock_tap <= '0;
      end else if (!full_rate || dly_clr) begin
         if (full_rate) tap <= '0;
         st       <= ST_IDLE;
         locked   <= 1'b0;
         lock_tap <= '0;
      end else if (dly_en) begin
         unique case (st)
            ST_IDLE: begin
               tap <= '0;
               st  <= ST_SETTLE;
            end
            ST_SETTLE: begin
               ref_word <= rx_word;
               cnt      <= '0;
               bad      <= 1'b0;
               st       <= ST_DWELL;
            end
            ST_DWELL: begin
               bad <= bad || diff;
               if (!last_word) begin
                  cnt <= cnt + 1'b1;
               end else if (tap != TAP_MAX) begin
                  tap <= tap + 1'b1;
                  st  <= ST_SETTLE;
               end else if (trk_found) begin
                  tap      <= ctr_tap;
                  lock_tap <= ctr_tap;
                  locked   <= 1'b1;
                  st       <= ST_LOCK;
               end else begin
                  tap <= '0;
                  st  <= ST_SETTLE;
               end
            end
            default: ;
         endcase
      end
   end

   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!align_mode && dly_en && dly_up && !dly_clr && tap != TAP_MAX)
      |=> tap == TAP_W'($past(tap) + 1'b1));

   assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!align_mode && dly_en && !dly_clr &&
       ((dly_up && tap == TAP_MAX) || (!dly_up && tap == '0))) |=> $stable(tap));

   assert_man_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!align_mode && dly_clr) |=> tap == '0);

   assert_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (align_act && !dly_en && !dly_clr) |=> $stable(tap));

   assert_lock_after_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(tap) == TAP_MAX);

   assert_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked ? (lock_tap == tap) : (lock_tap == '0));

   assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && align_act && !dly_clr) |=> (locked && $stable(tap)));

   assert_no_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trk_eval && tap == TAP_MAX && !trk_found) |=> (!locked && tap == '0));

   assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (align_act && dly_clr) |=> (!locked && tap == '0));

   assert_half_rate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (align_mode && !full_rate) |=> (!locked && $stable(tap)));
endmodule

// File: tb/rx_tap_align_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_tap_align_ctrl_tb_top;
   localparam int TAP_W  = 6;
   localparam int WORD_W = 10;
   localparam int SWEEP  = 321;
   localparam logic [WORD_W-1:0] PAT = 10'h2B5;

   // lo1, hi1, lo2, hi2, expect_lock, expect_tap
   localparam int NV = 7;
   localparam int VEC [NV][6] = '{
      '{10, 20,  1,  0, 1, 15},
      '{ 0,  3, 40, 50, 1, 45},
      '{ 5, 12, 30, 37, 1,  8},
      '{60, 63,  1,  0, 1, 61},
      '{ 0, 63,  1,  0, 1, 31},
      '{33, 33,  1,  0, 1, 33},
      '{ 1,  0,  1,  0, 0,  0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic full_rate = 1'b1, align_mode = 1'b0;
   logic dly_en = 1'b0, dly_up = 1'b0, dly_clr = 1'b0;
   logic [WORD_W-1:0] rx_word;
   logic [TAP_W-1:0]  tap, lock_tap;
   logic              locked;
   logic              ph = 1'b0;
   int lo1 = 1, hi1 = 0, lo2 = 1, hi2 = 0;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;
   always @(posedge clk) ph <= ~ph;

   function automatic bit in_eye(int t, int a1, int b1, int a2, int b2);
      return (t >= a1 && t <= b1) || (t >= a2 && t <= b2);
   endfunction

   assign rx_word = in_eye(int'(tap), lo1, hi1, lo2, hi2) ? PAT : (ph ? PAT : ~PAT);

   rx_tap_align_ctrl #(.TAP_W(TAP_W), .WORD_W(WORD_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .full_rate(full_rate), .align_mode(align_mode),
      .dly_en(dly_en), .dly_up(dly_up), .dly_clr(dly_clr), .rx_word(rx_word),
      .tap(tap), .locked(locked), .lock_tap(lock_tap)
   );

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic restart_align();
      dly_en = 1'b0; dly_clr = 1'b1;
      tick(1);
      dly_clr = 1'b0;
      check("R11 clear drops lock", int'(locked), 0);
      check("R11 clear zeroes tap", int'(tap), 0);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(2);
      check("R1 reset tap", int'(tap), 0);
      check("R1 reset locked", int'(locked), 0);
      check("R1 reset lock_tap", int'(lock_tap), 0);
      rst_n = 1'b1;
      tick(1);
      check("R1 after release tap", int'(tap), 0);

      // manual stepping
      dly_en = 1'b1; dly_up = 1'b1; tick(5);
      check("R2 up steps", int'(tap), 5);
      dly_up = 1'b0; tick(2);
      check("R2 down steps", int'(tap), 3);
      dly_en = 1'b0; dly_up = 1'b1; tick(3);
      check("R2 disabled hold", int'(tap), 3);
      dly_en = 1'b1; tick(70);
      check("R3 top saturate", int'(tap), 63);
      dly_up = 1'b0; tick(70);
      check("R3 bottom saturate", int'(tap), 0);
      dly_up = 1'b1; tick(10);
      check("R2 up again", int'(tap), 10);
      dly_clr = 1'b1; tick(1);
      check("R4 clear beats step", int'(tap), 0);
      dly_clr = 1'b0; dly_en = 1'b0;
      check("R8 unlocked report", int'(lock_tap), 0);

      // alignment idle without enable
      align_mode = 1'b1; tick(20);
      check("R5 idle tap", int'(tap), 0);
      check("R5 idle unlocked", int'(locked), 0);

      // table of eye windows
      for (int v = 0; v < NV; v++) begin
         lo1 = VEC[v][0]; hi1 = VEC[v][1]; lo2 = VEC[v][2]; hi2 = VEC[v][3];
         restart_align();
         dly_en = 1'b1; tick(SWEEP - 1);
         check("R6 no lock before sweep end", int'(locked), 0);
         tick(1);
         check("R7 lock flag", int'(locked), VEC[v][4]);
         check("R7 chosen tap", int'(tap), VEC[v][5]);
         check("R8 report tap", int'(lock_tap), VEC[v][4] ? VEC[v][5] : 0);
         if (VEC[v][4] == 0) begin
            tick(5);
            check("R10 sweep restarted", int'(tap), 1);
            check("R10 still unlocked", int'(locked), 0);
         end
      end

      // pause in the middle of a sweep
      lo1 = 10; hi1 = 20; lo2 = 1; hi2 = 0;
      restart_align();
      dly_en = 1'b1; tick(100);
      check("R5 sweep underway", int'(tap), 19);
      dly_en = 1'b0; tick(10);
      check("R5 paused tap", int'(tap), 19);
      dly_en = 1'b1; tick(SWEEP - 100);
      check("R6 lock after resume", int'(locked), 1);
      check("R7 tap after resume", int'(tap), 15);

      // manual inputs ignored while locked
      dly_up = 1'b1; tick(5);
      dly_up = 1'b0; tick(5);
      dly_en = 1'b0; tick(2);
      check("R9 tap held", int'(tap), 15);
      check("R9 lock held", int'(locked), 1);

      // clear in the same clock as the lock decision
      restart_align();
      dly_en = 1'b1; tick(SWEEP - 1);
      dly_clr = 1'b1; tick(1);
      dly_clr = 1'b0; dly_en = 1'b0;
      check("R11 clear at decision lock", int'(locked), 0);
      check("R11 clear at decision tap", int'(tap), 0);
      dly_en = 1'b1; tick(SWEEP);
      check("R11 retrain lock", int'(locked), 1);
      check("R11 retrain tap", int'(tap), 15);

      // half rate
      full_rate = 1'b0; tick(1);
      check("R12 lock dropped", int'(locked), 0);
      check("R12 tap held", int'(tap), 15);
      tick(400);
      check("R12 no training", int'(tap), 15);
      check("R12 still unlocked", int'(locked), 0);
      check("R8 report cleared", int'(lock_tap), 0);
      full_rate = 1'b1; tick(SWEEP);
      check("R12 full rate retrain", int'(locked), 1);
      check("R12 full rate tap", int'(tap), 15);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule